// File: doc/BRIEF.md
# Voltage Regulator Soft-Start Sequencer

This block is the digital start-up controller of a multiphase buck regulator. It watches three already-qualified logic levels (bias supply good, power enable and termination-rail enable) and a parallel voltage-identification code. From these it drives the code of the reference DAC, a control that parks the PWM outputs in high impedance, a ready flag and a phase status word.

Once all three enables are high, the sequence runs in order. A fixed wait comes first. The reference then climbs one LSB at a time to a fixed boot code and holds there. At the end of the hold, the identification code is read. A usable code starts a second ramp, in either direction, to that code less a programmed offset, and the block then reports ready. The all-ones code instead parks the block in a latched off state.

Losing any enable at any moment drops the block back to shutdown on the next clock edge. Only a low-then-high cycle of an enable or of the bias-good input clears the latched off state. The DAC code is the identification code minus the offset, floored at zero. The analog voltage table lies outside the block.

Top module: `vr_softstart_seq`

## Requirements
- R1: While rstN is low, and in shutdown, phase is 0, dacCode is 0, pwmHiZ is 1 and vrReady is 0.
- R2: The block leaves shutdown only when porGood, enPwr and enVtt are all high; with any one low it stays in phase 0.
- R3: The first-delay phase (phase 1) lasts exactly TD1_CYC cycles, with dacCode held at 0.
- R4: In the boot ramp (phase 2), dacCode rises by one every STEP_CYC cycles until it equals BOOT_CODE. The hold phase (phase 3) begins one cycle after dacCode reaches BOOT_CODE.
- R5: The hold lasts HOLD_CYC cycles when the identification code is unchanged across the last two samples. It is extended for as long as the code differs between consecutive clock samples.
- R6: A valid sampled code v gives a target of v - OFFSET_CODE, or 0 when v < OFFSET_CODE. Phase 4 steps dacCode one LSB toward the target, up or down, every STEP_CYC cycles. Phase 5 begins one cycle after dacCode equals the target.
- R7: A sampled code equal to OFF_CODE (all ones, 63 by default) enters phase 6. In phase 6, pwmHiZ is 1, vrReady is 0 and dacCode is 0. The block stays in phase 6 whatever the identification input does, until an enable or porGood goes low.
- R8: vrReady is high only in phase 5, and it rises only on leaving phase 4.
- R9: If porGood, enPwr or enVtt is low at a clock edge, the block is in phase 0 after that edge, with dacCode 0, pwmHiZ 1 and vrReady 0.
- R10: Changes of the identification input after the hold sample leave dacCode unchanged.
- R11: Phase encoding: 0 shutdown, 1 first delay, 2 boot ramp, 3 hold, 4 target ramp, 5 regulate, 6 latched off. No other value appears.
- R12: During either ramp, dacCode changes by at most one LSB per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| porGood | input | 1 | Bias supply above its power-on threshold |
| enPwr | input | 1 | Qualified power enable level |
| enVtt | input | 1 | Qualified termination-rail enable level |
| vidIn | input | CODE_W | Parallel voltage-identification code |
| dacCode | output | CODE_W | Reference DAC code |
| pwmHiZ | output | 1 | High: PWM outputs held in high impedance |
| vrReady | output | 1 | Output in regulation |
| phase | output | 3 | Current sequence phase (R11 encoding) |

## Verification
All outputs are registered, so every result is due one clock edge after its cause. Stimulus is driven and outputs are sampled on the falling edge. Each phase boundary is checked by counting rising edges from the edge at which the enables were applied. The expected counts are 1 for the delay, 1+TD1_CYC for the boot ramp, a further STEP_CYC*BOOT_CODE+1 for the hold, and HOLD_CYC after that for the target ramp or latched off. Regulation follows STEP_CYC*|target-BOOT_CODE|+1 cycles later. An enable loss is checked one edge after it is driven.

// File: rtl/vr_ssq_pkg.sv
package vr_ssq_pkg;

  typedef enum logic [2:0] {
    PH_SHUT  = 3'd0,
    PH_DELAY = 3'd1,
    PH_RAMP1 = 3'd2,
    PH_HOLD  = 3'd3,
    PH_RAMP2 = 3'd4,
    PH_REG   = 3'd5,
    PH_OFFL  = 3'd6
  } ssqPhase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearDac;
    logic rampBoot;
    logic rampTarget;
    logic latchTarget;
  } ssqStrobe_t;

endpackage

// File: rtl/vr_ssq_datapath.sv
module vr_ssq_datapath
  import vr_ssq_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int BOOT_CODE   = 20,
  parameter int OFFSET_CODE = 2,
  parameter int OFF_CODE    = 63,
  parameter int STEP_CYC    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ssqStrobe_t        stb,
  input  logic [CODE_W-1:0] vidIn,
  output logic [CODE_W-1:0] dacCode,
  output logic              atBoot,
  output logic              atTarget,
  output logic              vidStable,
  output logic              vidIsOff
);

  localparam int TW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [TW-1:0]     STEP_LAST = TW'(STEP_CYC - 1);
  localparam logic [CODE_W-1:0] BOOT_V    = CODE_W'(BOOT_CODE);
  localparam logic [CODE_W-1:0] OFS_V     = CODE_W'(OFFSET_CODE);
  localparam logic [CODE_W-1:0] OFF_V     = CODE_W'(OFF_CODE);

  logic [TW-1:0]     stepTimer;
  logic              stepTick;
  logic              ramping;
  logic [CODE_W-1:0] vidReg, vidPrev, target;

  assign ramping  = stb.rampBoot | stb.rampTarget;
  assign stepTick = ramping && (stepTimer == STEP_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepTimer <= '0;
    else if (!ramping || stepTick) stepTimer <= '0;
    else stepTimer <= stepTimer + TW'(1);
  end

  // two-stage sampling of the identification code
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vidReg  <= '0;
      vidPrev <= '0;
    end else begin
      vidReg  <= vidIn;
      vidPrev <= vidReg;
    end
  end

  assign vidStable = (vidReg == vidPrev);
  assign vidIsOff  = (vidReg == OFF_V);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) target <= '0;
    else if (stb.latchTarget) target <= (vidReg >= OFS_V) ? (vidReg - OFS_V) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dacCode <= '0;
    else if (stb.clearDac) dacCode <= '0;
    else if (stb.rampBoot && stepTick && (dacCode != BOOT_V))
      dacCode <= dacCode + CODE_W'(1);
    else if (stb.rampTarget && stepTick && (dacCode != target))
      dacCode <= (dacCode < target) ? dacCode + CODE_W'(1) : dacCode - CODE_W'(1);
  end

  assign atBoot   = (dacCode == BOOT_V);
  assign atTarget = (dacCode == target);

endmodule

// File: rtl/vr_ssq_ctrl.sv
module vr_ssq_ctrl
  import vr_ssq_pkg::*;
#(
  parameter int TD1_CYC  = 50,
  parameter int HOLD_CYC = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enAll,
  input  logic       atBoot,
  input  logic       atTarget,
  input  logic       vidStable,
  input  logic       vidIsOff,
  output ssqPhase_e  phaseQ,
  output ssqStrobe_t stb,
  output logic       pwmHiZ,
  output logic       vrReady
);

  localparam int CNT_TOP = (TD1_CYC > HOLD_CYC) ? TD1_CYC : HOLD_CYC;
  localparam int CW      = $clog2(CNT_TOP + 1);
  localparam logic [CW-1:0] CNT_MAX   = CW'(CNT_TOP - 1);
  localparam logic [CW-1:0] TD1_LAST  = CW'(TD1_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

  ssqPhase_e     phaseN;
  logic [CW-1:0] cnt;
  logic          holdDone;

  assign holdDone = (cnt >= HOLD_LAST);

  always_comb begin
    phaseN = phaseQ;
    if (!enAll) phaseN = PH_SHUT;
    else begin
      case (phaseQ)
        PH_SHUT:  phaseN = PH_DELAY;
        PH_DELAY: if (cnt == TD1_LAST) phaseN = PH_RAMP1;
        PH_RAMP1: if (atBoot) phaseN = PH_HOLD;
        PH_HOLD:  if (holdDone && vidStable) phaseN = vidIsOff ? PH_OFFL : PH_RAMP2;
        PH_RAMP2: if (atTarget) phaseN = PH_REG;
        PH_REG:   phaseN = PH_REG;
        PH_OFFL:  phaseN = PH_OFFL;
        default:  phaseN = PH_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_SHUT;
      cnt    <= '0;
    end else begin
      phaseQ <= phaseN;
      if (phaseN != phaseQ) cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + CW'(1);
    end
  end

  always_comb begin
    stb.clearDac    = (phaseN == PH_SHUT) || (phaseN == PH_DELAY) || (phaseN == PH_OFFL);
    stb.rampBoot    = (phaseQ == PH_RAMP1);
    stb.rampTarget  = (phaseQ == PH_RAMP2);
    stb.latchTarget = (phaseQ == PH_HOLD) && (phaseN == PH_RAMP2);
  end

  assign pwmHiZ  = (phaseQ == PH_SHUT) || (phaseQ == PH_OFFL);
  assign vrReady = (phaseQ == PH_REG);

endmodule

// File: rtl/vr_softstart_seq.sv
module vr_softstart_seq
  import vr_ssq_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int TD1_CYC     = 50,
  parameter int HOLD_CYC    = 16,
  parameter int STEP_CYC    = 2,
  parameter int BOOT_CODE   = 20,
  parameter int OFFSET_CODE = 2,
  parameter int OFF_CODE    = 63
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porGood,
  input  logic              enPwr,
  input  logic              enVtt,
  input  logic [CODE_W-1:0] vidIn,
  output logic [CODE_W-1:0] dacCode,
  output logic              pwmHiZ,
  output logic              vrReady,
  output logic [2:0]        phase
);

  logic       enAll, atBoot, atTarget, vidStable, vidIsOff;
  ssqStrobe_t stb;
  ssqPhase_e  phaseQ;

  assign enAll = porGood & enPwr & enVtt;
  assign phase = phaseQ;

  vr_ssq_ctrl #(.TD1_CYC(TD1_CYC), .HOLD_CYC(HOLD_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .enAll(enAll), .atBoot(atBoot), .atTarget(atTarget),
    .vidStable(vidStable), .vidIsOff(vidIsOff), .phaseQ(phaseQ), .stb(stb),
    .pwmHiZ(pwmHiZ), .vrReady(vrReady)
  );

  vr_ssq_datapath #(
    .CODE_W(CODE_W), .BOOT_CODE(BOOT_CODE), .OFFSET_CODE(OFFSET_CODE),
    .OFF_CODE(OFF_CODE), .STEP_CYC(STEP_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .vidIn(vidIn), .dacCode(dacCode),
    .atBoot(atBoot), .atTarget(atTarget), .vidStable(vidStable), .vidIsOff(vidIsOff)
  );

endmodule

// File: rtl/vr_ssq_checker.sv
module vr_ssq_checker #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              porGood,
  input logic              enPwr,
  input logic              enVtt,
  input logic [CODE_W-1:0] dacCode,
  input logic              pwmHiZ,
  input logic              vrReady,
  input logic [2:0]        phase
);

  logic enAll;
  assign enAll = porGood & enPwr & enVtt;

  // R9
  enable_loss_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enAll |=> (phase == 3'd0 && dacCode == '0 && pwmHiZ && !vrReady));

  // R8
  ready_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vrReady) |-> $past(phase) == 3'd4);

  // R7
  off_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase == 3'd6 |-> (pwmHiZ && !vrReady && dacCode == '0));

  // R7
  off_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd6 && enAll) |=> phase == 3'd6);

  // R3
  delay_dac_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase == 3'd1 |-> dacCode == '0);

  // R11
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase <= 3'd6);

  // R12
  ramp_slew_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == 3'd2 || phase == 3'd4) && $past(phase) == phase) |->
      (dacCode == $past(dacCode) ||
       dacCode == $past(dacCode) + CODE_W'(1) ||
       dacCode == $past(dacCode) - CODE_W'(1)));

endmodule

bind vr_softstart_seq vr_ssq_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .porGood(porGood), .enPwr(enPwr), .enVtt(enVtt),
  .dacCode(dacCode), .pwmHiZ(pwmHiZ), .vrReady(vrReady), .phase(phase)
);

// File: tb/vr_softstart_seq_bench.sv
module vr_softstart_seq_bench;

  localparam int W = 6, TD1 = 50, HOLD = 16, STEP = 2, BOOT = 20, OFS = 2, OFFC = 63;
  localparam int NV = 5;
  localparam logic [W-1:0] VEC_VID [NV] = '{6'd30, 6'd12, 6'd22, 6'd1, 6'd63};

  logic clk = 0, rstN = 0, porGood = 0, enPwr = 0, enVtt = 0;
  logic [W-1:0] vidIn = '0;
  logic [W-1:0] dacCode;
  logic pwmHiZ, vrReady;
  logic [2:0] phase;
  int cyc = 0, checks = 0, errors = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vr_softstart_seq #(.CODE_W(W), .TD1_CYC(TD1), .HOLD_CYC(HOLD), .STEP_CYC(STEP),
    .BOOT_CODE(BOOT), .OFFSET_CODE(OFS), .OFF_CODE(OFFC)) u_vr_softstart_seq (
    .clk(clk), .rstN(rstN), .porGood(porGood), .enPwr(enPwr), .enVtt(enVtt),
    .vidIn(vidIn), .dacCode(dacCode), .pwmHiZ(pwmHiZ), .vrReady(vrReady), .phase(phase));

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual cycles=%0d expected < 150000", cyc);
    finishRun();
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setEn(input logic p, input logic a, input logic b);
    porGood = p; enPwr = a; enVtt = b;
  endtask

  // waits until phase == p, returns edges since cycle stamp t0
  task automatic waitPhase(input logic [2:0] p, input int t0, output int n);
    int guard = 0;
    while (phase != p && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    n = cyc - t0;
  endtask

  function automatic int tgtOf(input int v);
    return (v >= OFS) ? v - OFS : 0;
  endfunction

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  int t0, n, nHold, nR2, tg;

  initial begin
    // R1: reset state
    cycles(2);
    chk("R1 phase", phase, 0); chk("R1 dac", dacCode, 0);
    chk("R1 hiz", pwmHiZ, 1); chk("R1 ready", vrReady, 0);
    rstN = 1;
    // R2: any single enable low keeps shutdown
    for (int k = 0; k < 3; k++) begin
      setEn(k != 0, k != 1, k != 2);
      cycles(20);
      chk("R2 partial enable", phase, 0);
      chk("R2 hiz held", pwmHiZ, 1);
    end

    // table walk
    for (int i = 0; i < NV; i++) begin
      setEn(0, 0, 0); vidIn = VEC_VID[i];
      cycles(3);
      chk("R9 shut before run", phase, 0);
      setEn(1, 1, 1); t0 = cyc;
      waitPhase(3'd1, t0, n); chk("R2 start", n, 1);
      waitPhase(3'd2, t0, n); chk("R3 delay length", n, 1 + TD1);
      chk("R3 dac at ramp start", dacCode, 0);
      cycles(STEP * 5);
      chk("R4 step rate", dacCode, 5);
      waitPhase(3'd3, t0, nHold);
      chk("R4 hold entry", nHold, 1 + TD1 + STEP * BOOT + 1);
      chk("R4 boot code", dacCode, BOOT);
      chk("R8 no ready in hold", vrReady, 0);
      if (VEC_VID[i] == OFFC) begin
        waitPhase(3'd6, t0, n); chk("R7 off entry", n, nHold + HOLD);
        chk("R7 off hiz", pwmHiZ, 1); chk("R7 off dac", dacCode, 0);
        vidIn = 6'd30; cycles(30);
        chk("R7 off latched", phase, 6);
        setEn(1, 0, 1); cycles(1);
        chk("R7 cleared by enable cycle", phase, 0);
        setEn(1, 1, 1); cycles(1);
        chk("R7 restart", phase, 1);
      end else begin
        tg = tgtOf(VEC_VID[i]);
        waitPhase(3'd4, t0, nR2); chk("R5 hold length", nR2, nHold + HOLD);
        chk("R5 hiz released", pwmHiZ, 0);
        waitPhase(3'd5, t0, n);
        chk("R6 ramp2 length", n, nR2 + STEP * absd(tg, BOOT) + 1);
        chk("R6 target code", dacCode, tg);
        chk("R8 ready", vrReady, 1);
      end
    end

    // R5 extended hold with unstable code; R10 ignore later VID
    setEn(0, 0, 0); vidIn = 6'd30; cycles(3);
    setEn(1, 1, 1); t0 = cyc;
    waitPhase(3'd3, t0, nHold);
    for (int j = 0; j < HOLD + 10; j++) begin
      vidIn = (j % 2 == 0) ? 6'd31 : 6'd30;
      @(negedge clk);
    end
    chk("R5 hold extended", phase, 3);
    vidIn = 6'd30;
    waitPhase(3'd5, t0, n);
    chk("R6 target after extension", dacCode, 28);
    vidIn = 6'd10; cycles(20);
    chk("R10 dac unchanged", dacCode, 28);
    chk("R10 still regulating", phase, 5);
    // R9 bias loss in regulate
    porGood = 0; cycles(1);
    chk("R9 phase", phase, 0); chk("R9 dac", dacCode, 0);
    chk("R9 hiz", pwmHiZ, 1); chk("R9 ready", vrReady, 0);
    // R9 enable loss mid target ramp
    setEn(1, 1, 1); vidIn = 6'd40; t0 = cyc;
    waitPhase(3'd4, t0, n); cycles(3);
    enVtt = 0; cycles(1);
    chk("R9 ramp abort phase", phase, 0);
    chk("R9 ramp abort dac", dacCode, 0);
    // R1 reset mid sequence
    setEn(1, 1, 1); cycles(70);
    rstN = 0; cycles(1);
    chk("R1 reset phase", phase, 0); chk("R1 reset dac", dacCode, 0);
    finishRun();
  end

endmodule